// File: doc/BRIEF.md
# Wake-up power-on sequencer

This block controls a timed power-up handshake for a battery-backed timekeeping device. While main power is absent, either an alarm-match strobe or an accepted kickstart pulse starts a power-on attempt. The block then pulls an open-drain power-enable line low and waits a bounded number of slow reference ticks for the main supply to be reported good. If the supply arrives in time, the block commits to the powered state. If it does not, the block releases the line back to high impedance.

After a successful power-on, an open-drain interrupt line signals which cause started the power-up. Two cause flags record this, one for the alarm and one for the kickstart. A power-off control bit drops to 0 automatically on success, and power stays enabled until software writes 1 to that bit. Software reads clear both flags. Events that arrive while an attempt is in progress, or while the device is powered, are ignored. Open-drain pins appear as drive-low enables: 1 pulls the pin low, and 0 leaves it at high impedance.

Top module: `wake_pwr_seq`

## Requirements
- R1: After reset the power-enable and interrupt drive enables are 0, both cause flags are 0 and the power-off bit is 1.
- R2: When idle with the supply not good, a one-cycle alarm strobe starts an attempt on the next edge: power-enable drive goes to 1 and the wake flag is set. An alarm strobe while the supply is good has no effect.
- R3: The kickstart input (active low) is accepted only after KICK_MIN consecutive low clock cycles. An accepted kickstart starts an attempt and sets the kick flag. A shorter low pulse has no effect.
- R4: If the supply is good during an attempt, the block enters the powered state at the next edge. The power-off bit becomes 0 and power-enable drive stays 1 for as long as the block remains powered.
- R5: The interrupt drive enable is 1 only in the powered state while at least one cause flag is 1. Otherwise it is 0, which is high impedance.
- R6: A write with data 1 in the powered state sets the power-off bit to 1, releases power-enable and returns the block to idle. A write with data 0 has no effect, and so does any write outside the powered state.
- R7: A flag-read strobe clears both cause flags, so the interrupt drive enable drops to 0.
- R8: Alarm and kickstart events during an attempt or in the powered state change no flag and no state.
- R9: The timeout counts only ticks that arrive while the oscillator is enabled and the countdown chain is not held in reset.
- R10: On the TIMEOUT_TICKS-th counted tick without a good supply, power-enable is released. The interrupt stays at high impedance and the cause flag stays set.
- R11: A good supply in the same cycle as the final counted tick gives a successful power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyGood | input | 1 | Main supply reported valid |
| kickN | input | 1 | Kickstart pin, active low, synchronous to clk |
| alarmHit | input | 1 | One-cycle alarm-match strobe |
| tickStb | input | 1 | One-cycle slow reference tick |
| oscOn | input | 1 | Oscillator enabled |
| chainRst | input | 1 | Countdown chain held in reset |
| wrEn | input | 1 | Write strobe for the power-off bit |
| wrData | input | 1 | Write data for the power-off bit |
| rdFlags | input | 1 | Flag-read strobe, clears both flags |
| pwrDrvLo | output | 1 | 1 pulls power-enable low, 0 leaves it at high impedance |
| irqDrvLo | output | 1 | 1 pulls the interrupt pin low, 0 leaves it at high impedance |
| wakeFlag | output | 1 | Alarm cause flag |
| kickFlag | output | 1 | Kickstart cause flag |
| pwrOffBit | output | 1 | Power-off control bit, 0 while powered |

## Verification
The embedded assertions check the following on every cycle:
- An idle alarm with no supply always leads to an attempt.
- The powered state holds until a write of 1 arrives.
- No flag-set strobe is raised outside idle.
- A flag read clears both flags.
- A kickstart is accepted once per low pulse.
- The tick counter freezes while ticks are not qualified.

The bench scenarios show the end-to-end orderings that no single-cycle property captures:
- The short and long kickstart widths.
- The full count to timeout, and the abort leaving a sticky flag.
- A good supply arriving together with the last tick.
- The interrupt appearing only after a committed power-on.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setWake;
    logic setKick;
    logic tickRun;
    logic tickClr;
    logic offClr;
    logic offSet;
  } ctlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic kickSeen;
    logic timeUp;
  } dpStat_t;

endpackage

// File: rtl/wps_dpath.sv
module wps_dpath
  import wps_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 2,
  parameter int KICK_MIN      = 250
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    kickN,
  input  logic    tickStb,
  input  logic    oscOn,
  input  logic    chainRst,
  input  logic    rdFlags,
  input  ctlStb_t stb,
  output dpStat_t stat,
  output logic    wakeFlag,
  output logic    kickFlag,
  output logic    pwrOffBit
);

  localparam int KCW = $clog2(KICK_MIN + 1);
  localparam int TCW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [KCW-1:0] KICK_SAT  = KCW'(KICK_MIN);
  localparam logic [KCW-1:0] KICK_LAST = KCW'(KICK_MIN - 1);
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TIMEOUT_TICKS - 1);

  logic [KCW-1:0] lowCnt;
  logic [TCW-1:0] tickCnt;
  logic           tickOk;

  // kickstart width filter: counts consecutive low cycles, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                lowCnt <= '0;
    else if (kickN)           lowCnt <= '0;
    else if (lowCnt != KICK_SAT) lowCnt <= lowCnt + 1'b1;
  end

  assign stat.kickSeen = !kickN && (lowCnt == KICK_LAST);

  // timeout counter runs only on qualified ticks
  assign tickOk = tickStb && oscOn && !chainRst;

  always_ff @(posedge clk) begin
    if (!rstN || stb.tickClr) tickCnt <= '0;
    else if (stb.tickRun && tickOk)
      tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
  end

  assign stat.timeUp = stb.tickRun && tickOk && (tickCnt == TICK_LAST);

  // cause flags: a set strobe wins over a read clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeFlag <= 1'b0;
      kickFlag <= 1'b0;
    end else begin
      if (stb.setWake)  wakeFlag <= 1'b1;
      else if (rdFlags) wakeFlag <= 1'b0;
      if (stb.setKick)  kickFlag <= 1'b1;
      else if (rdFlags) kickFlag <= 1'b0;
    end
  end

  // power-off control bit
  always_ff @(posedge clk) begin
    if (!rstN)           pwrOffBit <= 1'b1;
    else if (stb.offClr) pwrOffBit <= 1'b0;
    else if (stb.offSet) pwrOffBit <= 1'b1;
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlags && !stb.setWake && !stb.setKick) |=> (!wakeFlag && !kickFlag)); // R7

  AST_KICK_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stat.kickSeen |=> !stat.kickSeen); // R3

  AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tickRun && !stb.tickClr && !(oscOn && !chainRst)) |=> $stable(tickCnt)); // R9

  AST_OFF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.offClr |=> !pwrOffBit); // R4

endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyGood,
  input  logic    alarmHit,
  input  logic    wrEn,
  input  logic    wrData,
  input  logic    wakeFlag,
  input  logic    kickFlag,
  input  dpStat_t stat,
  output ctlStb_t stb,
  output logic    pwrDrvLo,
  output logic    irqDrvLo
);

  seqState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    stb    = '0;
    unique case (st)
      ST_IDLE: begin
        if (!supplyGood && (alarmHit || stat.kickSeen)) begin
          stNext      = ST_WAIT;
          stb.setWake = alarmHit;
          stb.setKick = stat.kickSeen;
          stb.tickClr = 1'b1;
        end
      end
      ST_WAIT: begin
        stb.tickRun = 1'b1;
        if (supplyGood) begin
          // success wins over a same-cycle timeout
          stNext     = ST_ON;
          stb.offClr = 1'b1;
        end else if (stat.timeUp) begin
          stNext = ST_IDLE;
        end
      end
      ST_ON: begin
        if (wrEn && wrData) begin
          stNext     = ST_IDLE;
          stb.offSet = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign pwrDrvLo = (st != ST_IDLE);
  assign irqDrvLo = (st == ST_ON) && (wakeFlag || kickFlag);

  AST_WAKE_START: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !supplyGood && alarmHit) |=> (st == ST_WAIT)); // R2

  AST_ON_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ON && !(wrEn && wrData)) |=> (st == ST_ON)); // R6

  AST_NO_LATE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE) |-> !(stb.setWake || stb.setKick)); // R8

  AST_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT && supplyGood) |=> (st == ST_ON)); // R11

endmodule

// File: rtl/wake_pwr_seq.sv
module wake_pwr_seq
  import wps_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 2,
  parameter int KICK_MIN      = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic kickN,
  input  logic alarmHit,
  input  logic tickStb,
  input  logic oscOn,
  input  logic chainRst,
  input  logic wrEn,
  input  logic wrData,
  input  logic rdFlags,
  output logic pwrDrvLo,
  output logic irqDrvLo,
  output logic wakeFlag,
  output logic kickFlag,
  output logic pwrOffBit
);

  ctlStb_t stb;
  dpStat_t stat;

  wps_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .alarmHit   (alarmHit),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .wakeFlag   (wakeFlag),
    .kickFlag   (kickFlag),
    .stat       (stat),
    .stb        (stb),
    .pwrDrvLo   (pwrDrvLo),
    .irqDrvLo   (irqDrvLo)
  );

  wps_dpath #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .KICK_MIN      (KICK_MIN)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .kickN     (kickN),
    .tickStb   (tickStb),
    .oscOn     (oscOn),
    .chainRst  (chainRst),
    .rdFlags   (rdFlags),
    .stb       (stb),
    .stat      (stat),
    .wakeFlag  (wakeFlag),
    .kickFlag  (kickFlag),
    .pwrOffBit (pwrOffBit)
  );

  AST_IRQ_ONLY_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    irqDrvLo |-> (pwrDrvLo && !pwrOffBit)); // R5

endmodule

// File: tb/wake_pwr_seq_tb_top.sv
module wake_pwr_seq_tb_top;

  localparam int TT = 4;
  localparam int KM = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0, kickN = 1'b1, alarmHit = 1'b0, tickStb = 1'b0;
  logic oscOn = 1'b1, chainRst = 1'b0, wrEn = 1'b0, wrData = 1'b0, rdFlags = 1'b0;
  logic pwrDrvLo, irqDrvLo, wakeFlag, kickFlag, pwrOffBit;

  always #4 clk = ~clk;

  wake_pwr_seq #(.TIMEOUT_TICKS(TT), .KICK_MIN(KM)) dut_i (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .kickN(kickN),
    .alarmHit(alarmHit), .tickStb(tickStb), .oscOn(oscOn), .chainRst(chainRst),
    .wrEn(wrEn), .wrData(wrData), .rdFlags(rdFlags),
    .pwrDrvLo(pwrDrvLo), .irqDrvLo(irqDrvLo), .wakeFlag(wakeFlag),
    .kickFlag(kickFlag), .pwrOffBit(pwrOffBit)
  );

  typedef struct {
    string tag;
    logic  pwr, irq, wk, kk, off;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic expect_out(string tag, logic pwr, logic irq, logic wk, logic kk, logic off);
    expItem_t it;
    it.tag = tag; it.pwr = pwr; it.irq = irq; it.wk = wk; it.kk = kk; it.off = off;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic cmp(string tag, string fld, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b", tag, fld, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      expItem_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      cmp(it.tag, "pwrDrvLo", pwrDrvLo, it.pwr);
      cmp(it.tag, "irqDrvLo", irqDrvLo, it.irq);
      cmp(it.tag, "wakeFlag", wakeFlag, it.wk);
      cmp(it.tag, "kickFlag", kickFlag, it.kk);
      cmp(it.tag, "pwrOffBit", pwrOffBit, it.off);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAlarm();
    alarmHit = 1'b1; step(1); alarmHit = 1'b0;
  endtask

  task automatic pulseTick(int n);
    for (int i = 0; i < n; i++) begin
      tickStb = 1'b1; step(1); tickStb = 1'b0; step(1);
    end
  endtask

  task automatic kickLow(int n);
    kickN = 1'b0; step(n); kickN = 1'b1;
  endtask

  task automatic readFlags();
    rdFlags = 1'b1; step(1); rdFlags = 1'b0;
  endtask

  task automatic writeOff(logic d);
    wrEn = 1'b1; wrData = d; step(1); wrEn = 1'b0; wrData = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    expect_out("R1 reset", 0, 0, 0, 0, 1);

    // alarm with supply good is ignored
    supplyGood = 1'b1; pulseAlarm();
    expect_out("R2 alarm with supply", 0, 0, 0, 0, 1);
    supplyGood = 1'b0; step(1);

    // alarm starts attempt
    pulseAlarm();
    expect_out("R2 alarm start", 1, 0, 1, 0, 1);
    kickLow(KM); step(1);
    expect_out("R8 kick during attempt", 1, 0, 1, 0, 1);
    supplyGood = 1'b1; step(1);
    expect_out("R4 R5 commit", 1, 1, 1, 0, 0);
    pulseAlarm(); kickLow(KM + 1); step(1);
    expect_out("R8 events while powered", 1, 1, 1, 0, 0);
    step(20);
    expect_out("R4 holds", 1, 1, 1, 0, 0);
    writeOff(1'b0);
    expect_out("R6 write zero", 1, 1, 1, 0, 0);
    readFlags();
    expect_out("R7 read clears", 1, 0, 0, 0, 0);
    writeOff(1'b1);
    expect_out("R6 release", 0, 0, 0, 0, 1);
    supplyGood = 1'b0; step(1);

    // kickstart width filter
    kickLow(KM - 1);
    expect_out("R3 short kick", 0, 0, 0, 0, 1);
    step(2);
    kickLow(KM);
    expect_out("R3 kick accepted", 1, 0, 0, 1, 1);

    // unqualified ticks
    oscOn = 1'b0; pulseTick(6);
    expect_out("R9 osc off", 1, 0, 0, 1, 1);
    oscOn = 1'b1; chainRst = 1'b1; pulseTick(6);
    expect_out("R9 chain reset", 1, 0, 0, 1, 1);
    chainRst = 1'b0;
    pulseTick(TT - 1);
    expect_out("R10 before timeout", 1, 0, 0, 1, 1);
    pulseTick(1);
    expect_out("R10 abort", 0, 0, 0, 1, 1);

    // new attempt, success on the final tick
    pulseAlarm();
    expect_out("R2 second attempt", 1, 0, 1, 1, 1);
    pulseTick(TT - 1);
    tickStb = 1'b1; supplyGood = 1'b1; step(1); tickStb = 1'b0;
    expect_out("R11 supply on last tick", 1, 1, 1, 1, 0);
    step(3);
    expect_out("R11 stays powered", 1, 1, 1, 1, 0);
    readFlags();
    expect_out("R7 R5 irq drops", 1, 0, 0, 0, 0);
    writeOff(1'b1);
    expect_out("R6 release again", 0, 0, 0, 0, 1);
    writeOff(1'b1);
    expect_out("R6 write in idle", 0, 0, 0, 0, 1);
    supplyGood = 1'b0; step(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule